// File: doc/BRIEF.md
# Watchdog Protected Register Interface

This block is the register front end of a watchdog timer. It sits between two host-side write ports and a separate countdown core. It holds the watchdog's settings: preload values for both expiry stages, enable, free-run, clock scale, interrupt type and reboot enable. It also turns host writes into one-cycle kick and flag-clear strobes for the core.

The memory-mapped window is byte addressed and accepts 1-, 2- and 4-byte writes. Refreshing the watchdog or changing a preload requires a key sequence first. Two byte values are written to the reload offset in order, and this opens the window for exactly one protected write. Any other write closes the window again.

The configuration and lock registers are on a separate config-space port. A lock bit there freezes the enable and free-run fields until reset. Readback on both ports is combinational on the presented address and size. Register updates appear on the outputs after the clock edge that samples the write.

Top module: `wdog_regif`

## Requirements
- R1: Asynchronous active-low reset sets rebootEn=1, fastClk=0, intType=0, freeRun=0, wdEnable=0, lock=0, both preloads to 0xFFFFF, kick=0 and flagClr=0, and closes the key window.
- R2: Preload and reload writes on the memory port act only after a key sequence. The sequence is a write whose size-masked data equals 0x80 at offset 0xC, then a write whose size-masked data equals 0x86 at offset 0xC. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Without the sequence these writes change nothing.
- R3: Once open, the window is closed by the next memory write that is not a key value, whatever its address or size. A 0x86 write that does not directly follow 0x80 does not open it.
- R4: An opened 2-byte write to 0xC with bit 8 set drives kick high for exactly one cycle.
- R5: An opened 2-byte write to 0xC with bit 9 or bit 12 set drives flagClr high for exactly one cycle.
- R6: An opened 4-byte write to 0x0 loads preload1, and one to 0x4 loads preload2, each from data bits [19:0].
- R7: An opened write of the wrong size to 0x0, 0x4 or 0xC changes no output, but it still closes the window.
- R8: memRdData is 0x1200 for a 2-byte access at 0xC while prevReboot is high. It is 0 for every other access.
- R9: A 2-byte config write at 0x60 sets rebootEn to the inverse of bit 5, fastClk to bit 2 and intType to bits [1:0]. A 2-byte config read at 0x60 returns those fields at the same bit positions.
- R10: A 1-byte config write at 0x68 sets lock from bit 0, wdEnable from bit 1 and freeRun from bit 2, unless lock is already set. In that case the write is ignored until reset. A 1-byte read at 0x68 returns those three bits.
- R11: Config writes of any other size or address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memWrEn | input | 1 | Memory-port write strobe |
| memAddr | input | 4 | Memory-port byte offset (write and read) |
| memSize | input | 2 | Access size: 0 byte, 1 half, 2 word |
| memWrData | input | 32 | Memory-port write data |
| memRdData | output | 32 | Memory-port read data |
| prevReboot | input | 1 | Previous-reboot flag held by the countdown core |
| cfgWrEn | input | 1 | Config-port write strobe |
| cfgAddr | input | 8 | Config-port offset (write and read) |
| cfgSize | input | 2 | Config access size, same coding |
| cfgWrData | input | 16 | Config-port write data |
| cfgRdData | output | 16 | Config-port read data |
| kick | output | 1 | One-cycle refresh strobe to the core |
| flagClr | output | 1 | One-cycle clear of the previous-reboot flag |
| preload1 | output | 20 | First-stage preload |
| preload2 | output | 20 | Second-stage preload |
| wdEnable | output | 1 | Watchdog enable |
| freeRun | output | 1 | Restart stage 1 after final expiry |
| fastClk | output | 1 | Fast decrement clock select |
| intType | output | 2 | Stage-1 interrupt type |
| rebootEn | output | 1 | Reboot on final expiry |

## Verification
The hardest situations to reach are the window-closing cases. These are a non-key write of the wrong size or to the wrong address landing while the window is open, and a stray 0x86 arriving without a preceding 0x80. Reaching either takes a specific multi-write order on the memory port.

The stimulus builds these orders directly. It opens the window with key writes of each size, then inserts a byte write, a half write to a preload offset, or a lone 0x86. Each such write is followed by a correctly sized protected write, which must then have no effect. A behavioural model is compared against every output on every cycle of the run.

// File: rtl/wdog_regif_pkg.sv
package wdog_regif_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    UNL_IDLE  = 2'd0,
    UNL_ARMED = 2'd1,
    UNL_OPEN  = 2'd2
  } unlSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldPre1;
    logic ldPre2;
    logic kickReq;
    logic clrReq;
    logic ldCfg;
    logic ldLock;
  } regStrobe_t;
endpackage

// File: rtl/wdog_regif_ctrl.sv
module wdog_regif_ctrl
  import wdog_regif_pkg::*;
#(
  parameter int MEM_AW = 4,
  parameter int CFG_AW = 8,
  parameter int DATA_W = 32,
  parameter logic [MEM_AW-1:0] RELOAD_OFS = 4'hC,
  parameter logic [MEM_AW-1:0] PRE1_OFS = 4'h0,
  parameter logic [MEM_AW-1:0] PRE2_OFS = 4'h4,
  parameter logic [CFG_AW-1:0] CFG_OFS = 8'h60,
  parameter logic [CFG_AW-1:0] LOCK_OFS = 8'h68,
  parameter logic [7:0] KEY_FIRST = 8'h80,
  parameter logic [7:0] KEY_SECOND = 8'h86
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memWrEn,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic [1:0]        memSize,
  input  logic [DATA_W-1:0] memWrData,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [1:0]        cfgSize,
  output regStrobe_t        strb
);
  localparam int KEY_PAD = DATA_W - 8;

  unlSt_e unlSt, unlNext;
  logic [DATA_W-1:0] maskedData;
  logic keyHit1, keyHit2, actOpen;

  always_comb begin
    unique case (memSize)
      SZ_BYTE: maskedData = {{(DATA_W-8){1'b0}}, memWrData[7:0]};
      SZ_HALF: maskedData = {{(DATA_W-16){1'b0}}, memWrData[15:0]};
      default: maskedData = memWrData;
    endcase
  end

  assign keyHit1 = (memAddr == RELOAD_OFS) && (maskedData == {{KEY_PAD{1'b0}}, KEY_FIRST});
  assign keyHit2 = (memAddr == RELOAD_OFS) && (maskedData == {{KEY_PAD{1'b0}}, KEY_SECOND})
                   && (unlSt == UNL_ARMED);
  assign actOpen = memWrEn && !keyHit1 && !keyHit2 && (unlSt == UNL_OPEN);

  always_comb begin
    unlNext = unlSt;
    if (memWrEn) begin
      if (keyHit1)      unlNext = UNL_ARMED;
      else if (keyHit2) unlNext = UNL_OPEN;
      else              unlNext = UNL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) unlSt <= UNL_IDLE;
    else       unlSt <= unlNext;
  end

  always_comb begin
    strb.kickReq = actOpen && (memAddr == RELOAD_OFS) && (memSize == SZ_HALF) && memWrData[8];
    strb.clrReq  = actOpen && (memAddr == RELOAD_OFS) && (memSize == SZ_HALF)
                   && (memWrData[9] || memWrData[12]);
    strb.ldPre1  = actOpen && (memAddr == PRE1_OFS) && (memSize == SZ_WORD);
    strb.ldPre2  = actOpen && (memAddr == PRE2_OFS) && (memSize == SZ_WORD);
    strb.ldCfg   = cfgWrEn && (cfgAddr == CFG_OFS) && (cfgSize == SZ_HALF);
    strb.ldLock  = cfgWrEn && (cfgAddr == LOCK_OFS) && (cfgSize == SZ_BYTE);
  end
endmodule

// File: rtl/wdog_regif_dp.sv
module wdog_regif_dp
  import wdog_regif_pkg::*;
#(
  parameter int MEM_AW = 4,
  parameter int CFG_AW = 8,
  parameter int DATA_W = 32,
  parameter int CFG_DW = 16,
  parameter int PRE_W = 20,
  parameter logic [MEM_AW-1:0] RELOAD_OFS = 4'hC,
  parameter logic [CFG_AW-1:0] CFG_OFS = 8'h60,
  parameter logic [CFG_AW-1:0] LOCK_OFS = 8'h68,
  parameter logic [DATA_W-1:0] FLAG_PATTERN = 32'h0000_1200
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] memWrData,
  input  logic [CFG_DW-1:0] cfgWrData,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic [1:0]        memSize,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [1:0]        cfgSize,
  input  logic              prevReboot,
  output logic [DATA_W-1:0] memRdData,
  output logic [CFG_DW-1:0] cfgRdData,
  output logic              kick,
  output logic              flagClr,
  output logic [PRE_W-1:0]  preload1,
  output logic [PRE_W-1:0]  preload2,
  output logic              wdEnable,
  output logic              freeRun,
  output logic              fastClk,
  output logic [1:0]        intType,
  output logic              rebootEn,
  output logic              lockBit
);
  localparam logic [PRE_W-1:0] PRE_RESET = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kick     <= 1'b0;
      flagClr  <= 1'b0;
      preload1 <= PRE_RESET;
      preload2 <= PRE_RESET;
      wdEnable <= 1'b0;
      freeRun  <= 1'b0;
      lockBit  <= 1'b0;
      fastClk  <= 1'b0;
      intType  <= 2'd0;
      rebootEn <= 1'b1;
    end else begin
      kick    <= strb.kickReq;
      flagClr <= strb.clrReq;
      if (strb.ldPre1) preload1 <= memWrData[PRE_W-1:0];
      if (strb.ldPre2) preload2 <= memWrData[PRE_W-1:0];
      if (strb.ldCfg) begin
        rebootEn <= ~cfgWrData[5];
        fastClk  <= cfgWrData[2];
        intType  <= cfgWrData[1:0];
      end
      if (strb.ldLock && !lockBit) begin
        lockBit  <= cfgWrData[0];
        wdEnable <= cfgWrData[1];
        freeRun  <= cfgWrData[2];
      end
    end
  end

  always_comb begin
    memRdData = '0;
    if (memAddr == RELOAD_OFS && memSize == SZ_HALF && prevReboot) memRdData = FLAG_PATTERN;
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgAddr == CFG_OFS && cfgSize == SZ_HALF) begin
      cfgRdData[5]   = ~rebootEn;
      cfgRdData[2]   = fastClk;
      cfgRdData[1:0] = intType;
    end else if (cfgAddr == LOCK_OFS && cfgSize == SZ_BYTE) begin
      cfgRdData[2] = freeRun;
      cfgRdData[1] = wdEnable;
      cfgRdData[0] = lockBit;
    end
  end
endmodule

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_regif_pkg::*;
#(
  parameter int MEM_AW = 4,
  parameter int CFG_AW = 8,
  parameter int DATA_W = 32,
  parameter int CFG_DW = 16,
  parameter int PRE_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memWrEn,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic [1:0]        memSize,
  input  logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] memRdData,
  input  logic              prevReboot,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [1:0]        cfgSize,
  input  logic [CFG_DW-1:0] cfgWrData,
  output logic [CFG_DW-1:0] cfgRdData,
  output logic              kick,
  output logic              flagClr,
  output logic [PRE_W-1:0]  preload1,
  output logic [PRE_W-1:0]  preload2,
  output logic              wdEnable,
  output logic              freeRun,
  output logic              fastClk,
  output logic [1:0]        intType,
  output logic              rebootEn
);
  regStrobe_t strb;
  logic lockBit;

  wdog_regif_ctrl #(.MEM_AW(MEM_AW), .CFG_AW(CFG_AW), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .memWrEn(memWrEn), .memAddr(memAddr), .memSize(memSize),
    .memWrData(memWrData), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgSize(cfgSize),
    .strb(strb)
  );

  wdog_regif_dp #(.MEM_AW(MEM_AW), .CFG_AW(CFG_AW), .DATA_W(DATA_W), .CFG_DW(CFG_DW),
                  .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memWrData(memWrData), .cfgWrData(cfgWrData),
    .memAddr(memAddr), .memSize(memSize), .cfgAddr(cfgAddr), .cfgSize(cfgSize),
    .prevReboot(prevReboot), .memRdData(memRdData), .cfgRdData(cfgRdData),
    .kick(kick), .flagClr(flagClr), .preload1(preload1), .preload2(preload2),
    .wdEnable(wdEnable), .freeRun(freeRun), .fastClk(fastClk), .intType(intType),
    .rebootEn(rebootEn), .lockBit(lockBit)
  );
endmodule

// File: rtl/wdog_regif_chk.sv
module wdog_regif_chk #(
  parameter int MEM_AW = 4,
  parameter int DATA_W = 32,
  parameter int PRE_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              memWrEn,
  input logic [MEM_AW-1:0] memAddr,
  input logic [1:0]        memSize,
  input logic [DATA_W-1:0] memWrData,
  input logic [DATA_W-1:0] memRdData,
  input logic              kick,
  input logic              flagClr,
  input logic [PRE_W-1:0]  preload1,
  input logic [PRE_W-1:0]  preload2,
  input logic              wdEnable,
  input logic              freeRun,
  input logic              lockBit
);
  p_kick_single_r4: assert property (@(posedge clk) disable iff (!rstN) kick |=> !kick);

  p_kick_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    kick |-> $past(memWrEn && memAddr == 4'hC && memSize == 2'd1 && memWrData[8]));

  p_clr_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    flagClr |-> $past(memWrEn && memAddr == 4'hC && memSize == 2'd1
                      && (memWrData[9] || memWrData[12])));

  p_pre_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(memWrEn && memSize == 2'd2) |-> ($stable(preload1) && $stable(preload2)));

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rstN) lockBit |=> lockBit);

  p_lock_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(lockBit) |-> ($stable(wdEnable) && $stable(freeRun)));

  p_rd_values_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memRdData == 32'h0) || (memRdData == 32'h1200));
endmodule

bind wdog_regif wdog_regif_chk #(.MEM_AW(MEM_AW), .DATA_W(DATA_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rstN(rstN), .memWrEn(memWrEn), .memAddr(memAddr), .memSize(memSize),
  .memWrData(memWrData), .memRdData(memRdData), .kick(kick), .flagClr(flagClr),
  .preload1(preload1), .preload2(preload2), .wdEnable(wdEnable), .freeRun(freeRun),
  .lockBit(lockBit)
);

// File: tb/wdog_regif_bench.sv
module wdog_regif_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memWrEn = 1'b0;
  logic [3:0] memAddr = 4'h0;
  logic [1:0] memSize = 2'd0;
  logic [31:0] memWrData = 32'h0;
  logic [31:0] memRdData;
  logic prevReboot = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgAddr = 8'h0;
  logic [1:0] cfgSize = 2'd0;
  logic [15:0] cfgWrData = 16'h0;
  logic [15:0] cfgRdData;
  logic kick, flagClr, wdEnable, freeRun, fastClk, rebootEn;
  logic [19:0] preload1, preload2;
  logic [1:0] intType;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  // reference model state
  int mKey = 0;
  bit mKick, mClr, mEn, mFree, mLock, mFast, mReboot;
  bit [1:0] mInt;
  bit [19:0] mPre1, mPre2;

  always #10 clk = ~clk;

  wdog_regif u_wdog_regif (
    .clk(clk), .rstN(rstN), .memWrEn(memWrEn), .memAddr(memAddr), .memSize(memSize),
    .memWrData(memWrData), .memRdData(memRdData), .prevReboot(prevReboot),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgSize(cfgSize), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .kick(kick), .flagClr(flagClr), .preload1(preload1),
    .preload2(preload2), .wdEnable(wdEnable), .freeRun(freeRun), .fastClk(fastClk),
    .intType(intType), .rebootEn(rebootEn)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mKey = 0; mKick = 0; mClr = 0; mEn = 0; mFree = 0; mLock = 0;
      mFast = 0; mReboot = 1; mInt = 0; mPre1 = 20'hFFFFF; mPre2 = 20'hFFFFF;
    end else begin
      bit [31:0] v;
      mKick = 0; mClr = 0;
      if (cfgWrEn && cfgAddr == 8'h60 && cfgSize == 2'd1) begin
        mReboot = !cfgWrData[5]; mFast = cfgWrData[2]; mInt = cfgWrData[1:0];
      end
      if (cfgWrEn && cfgAddr == 8'h68 && cfgSize == 2'd0 && !mLock) begin
        mLock = cfgWrData[0]; mEn = cfgWrData[1]; mFree = cfgWrData[2];
      end
      if (memWrEn) begin
        v = (memSize == 2'd0) ? (memWrData & 32'hFF) :
            (memSize == 2'd1) ? (memWrData & 32'hFFFF) : memWrData;
        if (memAddr == 4'hC && v == 32'h80) mKey = 1;
        else if (memAddr == 4'hC && v == 32'h86 && mKey == 1) mKey = 2;
        else begin
          if (mKey == 2) begin
            if (memAddr == 4'hC && memSize == 2'd1) begin
              mKick = memWrData[8];
              mClr = memWrData[9] | memWrData[12];
            end
            if (memAddr == 4'h0 && memSize == 2'd2) mPre1 = memWrData[19:0];
            if (memAddr == 4'h4 && memSize == 2'd2) mPre2 = memWrData[19:0];
          end
          mKey = 0;
        end
      end
    end
  end

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [15:0] expCfg;
    expCfg = 16'h0;
    if (cfgAddr == 8'h60 && cfgSize == 2'd1) expCfg = {10'h0, !mReboot, 2'b0, mFast, mInt};
    else if (cfgAddr == 8'h68 && cfgSize == 2'd0) expCfg = {13'h0, mFree, mEn, mLock};
    cmp("R4 kick", {31'h0, kick}, {31'h0, mKick});
    cmp("R5 flagClr", {31'h0, flagClr}, {31'h0, mClr});
    cmp("R6 preload1", {12'h0, preload1}, {12'h0, mPre1});
    cmp("R6 preload2", {12'h0, preload2}, {12'h0, mPre2});
    cmp("R10 wdEnable", {31'h0, wdEnable}, {31'h0, mEn});
    cmp("R10 freeRun", {31'h0, freeRun}, {31'h0, mFree});
    cmp("R9 fastClk", {31'h0, fastClk}, {31'h0, mFast});
    cmp("R9 intType", {30'h0, intType}, {30'h0, mInt});
    cmp("R9 rebootEn", {31'h0, rebootEn}, {31'h0, mReboot});
    cmp("R8 memRdData", memRdData,
        (memAddr == 4'hC && memSize == 2'd1 && prevReboot) ? 32'h1200 : 32'h0);
    cmp("R9/R10 cfgRdData", {16'h0, cfgRdData}, {16'h0, expCfg});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic memWr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    memWrEn = 1; memAddr = a; memSize = s; memWrData = d;
    tick();
    memWrEn = 0;
  endtask

  task automatic cfgWr(input logic [7:0] a, input logic [1:0] s, input logic [15:0] d);
    cfgWrEn = 1; cfgAddr = a; cfgSize = s; cfgWrData = d;
    tick();
    cfgWrEn = 0;
  endtask

  task automatic openKey(input logic [1:0] s);
    memWr(4'hC, s, 32'h80);
    memWr(4'hC, s, 32'h86);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    cmp("R1 preload1", {12'h0, preload1}, 32'hFFFFF);
    cmp("R1 rebootEn", {31'h0, rebootEn}, 32'h1);
    cmp("R1 enable/free/fast/int", {27'h0, wdEnable, freeRun, fastClk, intType}, 32'h0);
    rstN = 1;
    tick();

    // R2 protected write without key
    memWr(4'h0, 2'd2, 32'h0001_2345);
    cmp("R2 preload1 no key", {12'h0, preload1}, 32'hFFFFF);

    // R6 opened preload loads, upper bits dropped
    openKey(2'd0);
    memWr(4'h0, 2'd2, 32'hABC1_2345);
    cmp("R6 preload1", {12'h0, preload1}, 32'h12345);
    openKey(2'd1);
    memWr(4'h4, 2'd2, 32'hFFF0_000F);
    cmp("R6 preload2", {12'h0, preload2}, 32'h0000F);

    // R3 consumed after one use
    openKey(2'd2);
    memWr(4'h0, 2'd2, 32'h0000_0111);
    memWr(4'h0, 2'd2, 32'h0000_0222);
    cmp("R3 single use", {12'h0, preload1}, 32'h00111);
    // R3 lone second key
    memWr(4'hC, 2'd0, 32'h86);
    memWr(4'h0, 2'd2, 32'h0000_0333);
    cmp("R3 lone 0x86", {12'h0, preload1}, 32'h00111);
    // R3 non-key byte write closes
    openKey(2'd0);
    memWr(4'h8, 2'd0, 32'h55);
    memWr(4'h0, 2'd2, 32'h0000_0444);
    cmp("R3 closed by stray write", {12'h0, preload1}, 32'h00111);

    // R7 wrong size consumes
    openKey(2'd0);
    memWr(4'h0, 2'd1, 32'h0000_0555);
    cmp("R7 wrong size", {12'h0, preload1}, 32'h00111);
    memWr(4'h0, 2'd2, 32'h0000_0666);
    cmp("R7 consumed", {12'h0, preload1}, 32'h00111);
    openKey(2'd0);
    memWr(4'hC, 2'd2, 32'h0000_0100);
    cmp("R7 word reload no kick", {31'h0, kick}, 32'h0);

    // R4 kick pulse
    openKey(2'd0);
    memWr(4'hC, 2'd1, 32'h0000_0100);
    cmp("R4 kick high", {31'h0, kick}, 32'h1);
    cmp("R5 no clear with kick", {31'h0, flagClr}, 32'h0);
    tick();
    cmp("R4 kick one cycle", {31'h0, kick}, 32'h0);
    memWr(4'hC, 2'd1, 32'h0000_0100);
    cmp("R2 kick needs key", {31'h0, kick}, 32'h0);

    // R5 flag clear both positions
    openKey(2'd1);
    memWr(4'hC, 2'd1, 32'h0000_0200);
    cmp("R5 bit9", {31'h0, flagClr}, 32'h1);
    openKey(2'd2);
    memWr(4'hC, 2'd1, 32'h0000_1100);
    cmp("R5 bit12", {31'h0, flagClr}, 32'h1);
    cmp("R4 kick with bit12", {31'h0, kick}, 32'h1);

    // R8 reads
    prevReboot = 1; memAddr = 4'hC; memSize = 2'd1;
    tick();
    cmp("R8 flag read", memRdData, 32'h1200);
    memSize = 2'd2;
    tick();
    cmp("R8 word read", memRdData, 32'h0);
    memAddr = 4'h0; memSize = 2'd1;
    tick();
    cmp("R8 other offset", memRdData, 32'h0);
    prevReboot = 0; memAddr = 4'hC;
    tick();
    cmp("R8 flag low", memRdData, 32'h0);

    // R9 config
    cfgWr(8'h60, 2'd1, 16'h0027);
    cmp("R9 rebootEn", {31'h0, rebootEn}, 32'h0);
    cmp("R9 fast/int", {29'h0, fastClk, intType}, 32'h7);
    cfgAddr = 8'h60; cfgSize = 2'd1;
    tick();
    cmp("R9 readback", {16'h0, cfgRdData}, 32'h27);
    // R11 wrong size / address
    cfgWr(8'h60, 2'd0, 16'h0000);
    cfgWr(8'h64, 2'd1, 16'h0000);
    cmp("R11 ignored", {30'h0, rebootEn, fastClk}, 32'h1);

    // R10 lock
    cfgWr(8'h68, 2'd0, 16'h0006);
    cmp("R10 en+free", {30'h0, wdEnable, freeRun}, 32'h3);
    cfgWr(8'h68, 2'd0, 16'h0003);
    cmp("R10 lock set", {30'h0, wdEnable, freeRun}, 32'h2);
    cfgWr(8'h68, 2'd0, 16'h0000);
    cmp("R10 frozen", {31'h0, wdEnable}, 32'h1);
    cfgAddr = 8'h68; cfgSize = 2'd0;
    tick();
    cmp("R10 readback", {16'h0, cfgRdData}, 32'h3);

    // R1 reset clears lock and closes key window
    openKey(2'd0);
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    tick();
    cmp("R1 lock cleared", {16'h0, cfgRdData}, 32'h0);
    memWr(4'h0, 2'd2, 32'h0000_0777);
    cmp("R1 key closed", {12'h0, preload1}, 32'hFFFFF);
    cfgWr(8'h68, 2'd0, 16'h0002);
    cmp("R10 writable after reset", {31'h0, wdEnable}, 32'h1);

    repeat (3) tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule